// File: doc/BRIEF.md
# Pseudo-SRAM bus cycle decoder

This block sits on the device side of a 16-bit pseudo-SRAM bus. On every rising edge of `clk` it samples the chip select, the address-valid strobe, the output and write enables, the configuration-space select and the two byte enables. It classifies the cycle as one of eleven bus operations. The classification depends on the operating mode, which is held in a bus configuration register: an asynchronous/page mode, or a synchronous burst mode that tracks an open burst across cycles.

The block also holds a refresh configuration register, whose power-down bit arms a deep power-down state. A rising chip select enters that state, and the next falling chip select leaves it. From the classification the block drives per-lane data enables, the read data (array or configuration word), a stall indicator with programmable polarity and its enable, and a simple registered read/write strobe interface towards the memory array.

All results are registered. The outputs seen after an edge describe the cycle whose pins that edge sampled.

Top module: `psram_cycle_decoder`

## Requirements
- R1: After reset, `op_o` is 0 (standby), and no lane, strobe or stall enable is active. The bus configuration word is 0x8400: bit 15 = 1 selects asynchronous mode, and bit 10 = 1 makes the stall output active-high. The refresh configuration word is 0x0010: bit 4 = 1 leaves deep power-down disarmed.
- R2: With `sel_n` = 1 (and not powered down), `op_o` = 0. `dq_oe_o` = 0, `stall_oe_o` = 0, and neither array strobe is active.
- R3: In asynchronous mode, with `sel_n` = 0 and `cfg_space` = 0, the cycle type depends on the enables, and `adv_n` has no effect.
  - `wr_en_n` = 0 gives a write (`op_o` = 3): `arr_wr_o` = 1 and `arr_wdata_o` = `dq_i`.
  - Otherwise `out_en_n` = 0 gives a read (`op_o` = 2): `arr_rd_o` = 1 and `dq_o` carries `arr_rdata_i`.
- R4: `byte_en_n[0]` low selects lane 0 (`dq[7:0]`), and `byte_en_n[1]` low selects lane 1 (`dq[15:8]`). `dq_oe_o` and `arr_be_o` carry the selected lanes as active-high bits. An undriven lane of `dq_o` reads 0.
- R5: With `sel_n` = 0 and `cfg_space` = 1, the configuration registers are accessed.
  - `wr_en_n` = 0 is a configuration write (`op_o` = 5). It loads `dq_i` into the bus configuration word when `cfg_sel` = 1, or into the refresh configuration word when `cfg_sel` = 0.
  - `out_en_n` = 0 with `wr_en_n` = 1 is a configuration read (`op_o` = 4). It drives the selected word on `dq_o` over the enabled lanes.
  - No other cycle changes either word.
- R6: `stall_oe_o` = 1 whenever `sel_n` = 0 and the part is not powered down. The block is busy on initial burst cycles, and on configuration cycles in synchronous mode. `stall_o` equals busy when bus configuration bit 10 = 1, and equals its inverse when bit 10 = 0.
- R7: With bus configuration bit 15 = 0 (synchronous mode) and `adv_n` = 0, the cycle opens a burst or a configuration access.
  - With `cfg_space` = 0, `wr_en_n` = 0 gives initial burst write (`op_o` = 7), and `wr_en_n` = 1 gives initial burst read (`op_o` = 6), whatever `out_en_n` is.
  - With `cfg_space` = 1, decoding follows R5 and opens a configuration burst.
  - Any other combination is a no-op that opens no burst.
- R8: In synchronous mode with `adv_n` = 1 inside an open burst, the cycle continues the burst (`op_o` = 8).
  - A read burst strobes `arr_rd_o` and drives array data. A write burst strobes `arr_wr_o`. A configuration-read burst drives the register word. A configuration-write burst moves nothing.
  - In a read or configuration-read burst, `out_en_n` = 1 is a suspend instead (`op_o` = 9): the lanes float and the burst stays open.
  - Without an open burst the cycle is a no-op. `sel_n` = 1 closes any burst.
- R9: When refresh configuration bit 4 is 0 and `sel_n` rises, that cycle and every later cycle with `sel_n` = 1 give `op_o` = 10 (deep power-down). All lane, stall and strobe outputs are off, and the other pins are ignored.
- R10: The first cycle with `sel_n` = 0 during deep power-down still gives `op_o` = 10 with all outputs quiet, and it restores both configuration words to their reset values. The following cycle is decoded normally.
- R11: A cycle with `sel_n` = 0 that matches none of the above is a no-op (`op_o` = 1). It has no lanes and no strobes, and `stall_oe_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, also the burst clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| cfg_space | input | 1 | High selects the configuration registers |
| byte_en_n | input | 2 | Byte-lane enables, active low, bit 0 = low lane |
| cfg_sel | input | 1 | 1 = bus configuration word, 0 = refresh configuration word |
| dq_i | input | 16 | Data bus as driven by the host |
| dq_o | output | 16 | Data driven by the device, 0 on disabled lanes |
| dq_oe_o | output | 2 | Per-lane output enable |
| stall_o | output | 1 | Stall indicator with programmable polarity |
| stall_oe_o | output | 1 | Stall output enable |
| op_o | output | 4 | Classified operation of the last sampled cycle |
| arr_rd_o | output | 1 | Array read strobe |
| arr_wr_o | output | 1 | Array write strobe |
| arr_be_o | output | 2 | Array byte enables, active high |
| arr_wdata_o | output | 16 | Array write data |
| arr_rdata_i | input | 16 | Array read data, returned in the strobe cycle |

## Verification
Every output is one register stage behind the pins, so the bench drives a cycle just after a rising edge and compares one edge later, just past it. A configuration write takes effect at the edge that samples it, and the bench's model changes mode and polarity for the very next cycle. The burst state is one cycle deep, so each synchronous sweep runs a triplet of cycles: a standby, then an opening cycle, then a following cycle, checked edge by edge. Power-down entry, the cycles held inside it, the exit cycle and the restored registers are each checked on consecutive edges.

// File: rtl/psram_dec_pkg.sv
package psram_dec_pkg;

    localparam int CFG_W    = 16;
    localparam int MODE_BIT = 15;  // 1 = asynchronous, 0 = synchronous burst
    localparam int POL_BIT  = 10;  // 1 = stall active high
    localparam int PD_BIT   = 4;   // 0 arms deep power-down

    localparam logic [CFG_W-1:0] BUS_CFG_RST = 16'h8400;
    localparam logic [CFG_W-1:0] REF_CFG_RST = 16'h0010;

    typedef enum logic [3:0] {
        OP_IDLE = 4'd0,
        OP_NOP  = 4'd1,
        OP_RD   = 4'd2,
        OP_WR   = 4'd3,
        OP_CRD  = 4'd4,
        OP_CWR  = 4'd5,
        OP_BRI  = 4'd6,
        OP_BWI  = 4'd7,
        OP_BCT  = 4'd8,
        OP_BSP  = 4'd9,
        OP_DPD  = 4'd10
    } op_e;

    typedef enum logic [2:0] {
        BD_NONE = 3'd0,
        BD_RD   = 3'd1,
        BD_WR   = 3'd2,
        BD_CRD  = 3'd3,
        BD_CWR  = 3'd4
    } bdir_e;

endpackage

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs
    import psram_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             sel_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             restore_i,
    output logic [CFG_W-1:0] bcr_o,
    output logic [CFG_W-1:0] rcr_o
);

    typedef struct packed {
        logic [CFG_W-1:0] bus;
        logic [CFG_W-1:0] refr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (restore_i) begin
            cfg_d.bus  = BUS_CFG_RST;
            cfg_d.refr = REF_CFG_RST;
        end else if (wr_i) begin
            if (sel_i) cfg_d.bus  = wdata_i;
            else       cfg_d.refr = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.bus  <= BUS_CFG_RST;
            cfg_q.refr <= REF_CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign bcr_o = cfg_q.bus;
    assign rcr_o = cfg_q.refr;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i || restore_i) |=> ($stable(bcr_o) && $stable(rcr_o))); // R5

    AST_CFG_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (bcr_o == BUS_CFG_RST && rcr_o == REF_CFG_RST)); // R10

endmodule

// File: rtl/psram_pd_ctrl.sv
module psram_pd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic pd_arm_i,
    output logic dpd_now_o,
    output logic dpd_exit_o
);

    typedef struct packed {
        logic sel_prev;
        logic dpd;
    } pd_t;

    pd_t pd_d, pd_q;
    logic enter;

    always_comb begin
        enter      = !pd_q.dpd && sel_n && !pd_q.sel_prev && pd_arm_i;
        dpd_exit_o = pd_q.dpd && !sel_n;
        dpd_now_o  = pd_q.dpd || enter;
        pd_d.sel_prev = sel_n;
        pd_d.dpd      = enter || (pd_q.dpd && !dpd_exit_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q.sel_prev <= 1'b1;
            pd_q.dpd      <= 1'b0;
        end else begin
            pd_q <= pd_d;
        end
    end

    AST_DPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_q.dpd && sel_n) |=> pd_q.dpd); // R9

    AST_DPD_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_q.dpd && !sel_n) |=> !pd_q.dpd); // R10

endmodule

// File: rtl/psram_op_decode.sv
module psram_op_decode
    import psram_dec_pkg::*;
(
    input  logic  sel_n,
    input  logic  adv_n,
    input  logic  out_en_n,
    input  logic  wr_en_n,
    input  logic  cfg_space,
    input  logic  async_mode,
    input  logic  dpd_now,
    input  bdir_e bdir_q,
    output op_e   op_o,
    output bdir_e bdir_d
);

    always_comb begin
        op_o   = OP_NOP;
        bdir_d = bdir_q;
        if (dpd_now) begin
            op_o   = OP_DPD;
            bdir_d = BD_NONE;
        end else if (sel_n) begin
            op_o   = OP_IDLE;
            bdir_d = BD_NONE;
        end else if (async_mode) begin
            bdir_d = BD_NONE;
            if (cfg_space) begin
                if (!wr_en_n)       op_o = OP_CWR;
                else if (!out_en_n) op_o = OP_CRD;
                else                op_o = OP_NOP;
            end else begin
                if (!wr_en_n)       op_o = OP_WR;
                else if (!out_en_n) op_o = OP_RD;
                else                op_o = OP_NOP;
            end
        end else if (!adv_n) begin
            if (!cfg_space) begin
                if (!wr_en_n) begin
                    op_o   = OP_BWI;
                    bdir_d = BD_WR;
                end else begin
                    op_o   = OP_BRI;
                    bdir_d = BD_RD;
                end
            end else if (!wr_en_n) begin
                op_o   = OP_CWR;
                bdir_d = BD_CWR;
            end else if (!out_en_n) begin
                op_o   = OP_CRD;
                bdir_d = BD_CRD;
            end else begin
                op_o   = OP_NOP;
                bdir_d = BD_NONE;
            end
        end else begin
            case (bdir_q)
                BD_RD, BD_CRD: op_o = out_en_n ? OP_BSP : OP_BCT;
                BD_WR, BD_CWR: op_o = OP_BCT;
                default:       op_o = OP_NOP;
            endcase
        end
    end

endmodule

// File: rtl/psram_cycle_decoder.sv
module psram_cycle_decoder
    import psram_dec_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n,
    input  logic                 adv_n,
    input  logic                 out_en_n,
    input  logic                 wr_en_n,
    input  logic                 cfg_space,
    input  logic [DW/8-1:0]      byte_en_n,
    input  logic                 cfg_sel,
    input  logic [DW-1:0]        dq_i,
    output logic [DW-1:0]        dq_o,
    output logic [DW/8-1:0]      dq_oe_o,
    output logic                 stall_o,
    output logic                 stall_oe_o,
    output logic [3:0]           op_o,
    output logic                 arr_rd_o,
    output logic                 arr_wr_o,
    output logic [DW/8-1:0]      arr_be_o,
    output logic [DW-1:0]        arr_wdata_o,
    input  logic [DW-1:0]        arr_rdata_i
);

    localparam int LANES = DW / 8;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] lanes;
        logic             rd;
        logic             wr;
        logic [LANES-1:0] be;
        logic [DW-1:0]    wdata;
        logic             from_arr;
        logic [CFG_W-1:0] cword;
        logic             soe;
        logic             st;
        bdir_e            bdir;
        logic             csel;
    } out_t;

    out_t o_d, o_q;

    logic [CFG_W-1:0] bcr, rcr;
    logic             async_mode, stall_pol;
    logic             dpd_now, dpd_exit;
    op_e              op_now;
    bdir_e            bdir_next;
    logic             cfg_wr, busy;
    logic [DW-1:0]    rd_word;

    assign async_mode = bcr[MODE_BIT];
    assign stall_pol  = bcr[POL_BIT];
    assign cfg_wr     = (op_now == OP_CWR);

    psram_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cfg_wr),
        .sel_i     (cfg_sel),
        .wdata_i   (dq_i[CFG_W-1:0]),
        .restore_i (dpd_exit),
        .bcr_o     (bcr),
        .rcr_o     (rcr)
    );

    psram_pd_ctrl u_pd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .pd_arm_i   (!rcr[PD_BIT]),
        .dpd_now_o  (dpd_now),
        .dpd_exit_o (dpd_exit)
    );

    psram_op_decode u_dec (
        .sel_n      (sel_n),
        .adv_n      (adv_n),
        .out_en_n   (out_en_n),
        .wr_en_n    (wr_en_n),
        .cfg_space  (cfg_space),
        .async_mode (async_mode),
        .dpd_now    (dpd_now),
        .bdir_q     (o_q.bdir),
        .op_o       (op_now),
        .bdir_d     (bdir_next)
    );

    always_comb begin
        o_d          = o_q;
        busy         = 1'b0;
        o_d.op       = op_now;
        o_d.bdir     = bdir_next;
        o_d.lanes    = '0;
        o_d.rd       = 1'b0;
        o_d.wr       = 1'b0;
        o_d.be       = '0;
        o_d.from_arr = 1'b0;
        o_d.soe      = !sel_n && !dpd_now;
        case (op_now)
            OP_RD: begin
                o_d.rd       = 1'b1;
                o_d.be       = ~byte_en_n;
                o_d.lanes    = ~byte_en_n;
                o_d.from_arr = 1'b1;
            end
            OP_WR: begin
                o_d.wr    = 1'b1;
                o_d.be    = ~byte_en_n;
                o_d.wdata = dq_i;
            end
            OP_CRD: begin
                o_d.lanes = ~byte_en_n;
                o_d.cword = cfg_sel ? bcr : rcr;
                o_d.csel  = cfg_sel;
                busy      = !async_mode;
            end
            OP_CWR: begin
                o_d.csel = cfg_sel;
                busy     = !async_mode;
            end
            OP_BRI, OP_BWI: busy = 1'b1;
            OP_BCT: begin
                case (o_q.bdir)
                    BD_RD: begin
                        o_d.rd       = 1'b1;
                        o_d.be       = ~byte_en_n;
                        o_d.lanes    = ~byte_en_n;
                        o_d.from_arr = 1'b1;
                    end
                    BD_WR: begin
                        o_d.wr    = 1'b1;
                        o_d.be    = ~byte_en_n;
                        o_d.wdata = dq_i;
                    end
                    BD_CRD: begin
                        o_d.lanes = ~byte_en_n;
                        o_d.cword = o_q.csel ? bcr : rcr;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
        o_d.st = o_d.soe && (stall_pol ? busy : !busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rd_word = o_q.from_arr ? arr_rdata_i : DW'(o_q.cword);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dq_o[g*8 +: 8] = o_q.lanes[g] ? rd_word[g*8 +: 8] : 8'h00;
    end

    assign dq_oe_o     = o_q.lanes;
    assign stall_o     = o_q.st;
    assign stall_oe_o  = o_q.soe;
    assign op_o        = o_q.op;
    assign arr_rd_o    = o_q.rd;
    assign arr_wr_o    = o_q.wr;
    assign arr_be_o    = o_q.be;
    assign arr_wdata_o = o_q.wdata;

    AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == 4'(OP_IDLE)) |-> (dq_oe_o == '0 && !stall_oe_o && !arr_rd_o && !arr_wr_o)); // R2

    AST_DPD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == 4'(OP_DPD)) |-> (dq_oe_o == '0 && !stall_oe_o && !arr_rd_o && !arr_wr_o)); // R9

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd_o && arr_wr_o)); // R3

    AST_SUSPEND_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == 4'(OP_BSP)) |-> (dq_oe_o == '0 && !arr_rd_o)); // R8

    AST_ASYNC_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(async_mode) |-> !(op_o inside {4'(OP_BRI), 4'(OP_BWI), 4'(OP_BCT), 4'(OP_BSP)})); // R7

endmodule

// File: tb/sim_psram_cycle_decoder.sv
module sim_psram_cycle_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p_sel = 1'b1, p_adv = 1'b1, p_oe = 1'b1, p_we = 1'b1, p_cfg = 1'b0;
    logic [1:0]  p_be = 2'b11;
    logic        p_csel = 1'b0;
    logic [15:0] p_dq = 16'h0010;
    logic [15:0] rdata = 16'hA55A;
    logic [15:0] dq_o, arr_wdata;
    logic [1:0]  dq_oe, arr_be;
    logic        stall, stall_oe, arr_rd, arr_wr;
    logic [3:0]  op;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench model state
    bit          m_async = 1, m_pol = 1;
    logic [15:0] m_bcr = 16'h8400, m_rcr = 16'h0010;
    int          m_dir = 0;
    bit          m_csel = 0;
    logic [3:0]  e_op;
    logic [1:0]  e_lanes, e_be;
    logic        e_rd, e_wr, e_soe, e_st;
    logic [15:0] e_dq, e_wd;

    always #5 clk = ~clk;

    psram_cycle_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(p_sel), .adv_n(p_adv),
        .out_en_n(p_oe), .wr_en_n(p_we), .cfg_space(p_cfg),
        .byte_en_n(p_be), .cfg_sel(p_csel), .dq_i(p_dq),
        .dq_o(dq_o), .dq_oe_o(dq_oe), .stall_o(stall), .stall_oe_o(stall_oe),
        .op_o(op), .arr_rd_o(arr_rd), .arr_wr_o(arr_wr), .arr_be_o(arr_be),
        .arr_wdata_o(arr_wdata), .arr_rdata_i(rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic setp(input logic s, input logic a, input logic o, input logic w,
                        input logic c, input logic [1:0] b, input logic cs, input logic [15:0] d);
        p_sel = s; p_adv = a; p_oe = o; p_we = w; p_cfg = c; p_be = b; p_csel = cs; p_dq = d;
    endtask

    task automatic predict();
        bit busy;
        logic [15:0] msk;
        busy = 0;
        e_lanes = 0; e_rd = 0; e_wr = 0; e_be = 0; e_dq = 0; e_wd = 0;
        if (p_sel) begin
            e_op = 0; m_dir = 0;
        end else if (m_async) begin
            m_dir = 0;
            if (p_cfg) e_op = !p_we ? 4'd5 : (!p_oe ? 4'd4 : 4'd1);
            else       e_op = !p_we ? 4'd3 : (!p_oe ? 4'd2 : 4'd1);
        end else if (!p_adv) begin
            if (!p_cfg) begin
                if (!p_we) begin e_op = 7; m_dir = 2; end
                else       begin e_op = 6; m_dir = 1; end
            end else if (!p_we) begin e_op = 5; m_dir = 4; end
            else if (!p_oe)     begin e_op = 4; m_dir = 3; end
            else                begin e_op = 1; m_dir = 0; end
        end else begin
            case (m_dir)
                1, 3:    e_op = p_oe ? 4'd9 : 4'd8;
                2, 4:    e_op = 8;
                default: e_op = 1;
            endcase
        end
        case (e_op)
            2: begin e_rd = 1; e_be = ~p_be; e_lanes = ~p_be; e_dq = rdata; end
            3: begin e_wr = 1; e_be = ~p_be; e_wd = p_dq; end
            4: begin e_lanes = ~p_be; e_dq = p_csel ? m_bcr : m_rcr; m_csel = p_csel; busy = !m_async; end
            5: begin m_csel = p_csel; busy = !m_async; end
            6, 7: busy = 1;
            8: begin
                if (m_dir == 1) begin e_rd = 1; e_be = ~p_be; e_lanes = ~p_be; e_dq = rdata; end
                if (m_dir == 2) begin e_wr = 1; e_be = ~p_be; e_wd = p_dq; end
                if (m_dir == 3) begin e_lanes = ~p_be; e_dq = m_csel ? m_bcr : m_rcr; end
            end
            default: ;
        endcase
        msk = {{8{e_lanes[1]}}, {8{e_lanes[0]}}};
        e_dq = e_dq & msk;
        e_soe = (e_op != 0);
        e_st = e_soe && (m_pol ? busy : !busy);
        if (e_op == 5) begin
            if (p_csel) m_bcr = p_dq; else m_rcr = p_dq;
            m_async = m_bcr[15];
            m_pol = m_bcr[10];
        end
    endtask

    task automatic cycle(input string tag);
        logic [63:0] a, e;
        predict();
        @(posedge clk); #1;
        a = {12'h0, op, dq_oe, arr_rd, arr_wr, arr_be, stall_oe, stall, dq_o, (arr_wr ? arr_wdata : 16'h0)};
        e = {12'h0, e_op, e_lanes, e_rd, e_wr, e_be, e_soe, e_st, e_dq, e_wd};
        chk(tag, a, e);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset outputs", {op, dq_oe, arr_rd, arr_wr, arr_be, stall_oe, stall, dq_o}, 64'h0);
        rst_n = 1'b1;
        step();

        // R1 / R5: register readback at reset values
        setp(0, 1, 0, 1, 1, 2'b00, 1, 16'h0010); cycle("R1 R5 read bus config");
        setp(0, 1, 0, 1, 1, 2'b00, 0, 16'h0010); cycle("R1 R5 read refresh config");

        // R2 R3 R4 R11: sweep in asynchronous mode
        for (int i = 0; i < 128; i++) begin
            setp(i[6], i[5], i[4], i[3], i[2], i[1:0], 0, 16'h0010);
            cycle("R2 R3 R4 R11 async sweep");
        end

        // R5: write and read back the refresh word, then restore
        setp(0, 1, 1, 0, 1, 2'b00, 0, 16'h00F0); cycle("R5 write refresh");
        setp(0, 1, 0, 1, 1, 2'b00, 0, 16'h0010); cycle("R5 read refresh");
        setp(0, 1, 1, 1, 1, 2'b10, 0, 16'h0010); cycle("R5 R11 idle cfg no effect");
        setp(0, 1, 0, 1, 1, 2'b10, 0, 16'h0010); cycle("R5 R4 read refresh low lane");
        setp(0, 1, 1, 0, 1, 2'b00, 0, 16'h0010); cycle("R5 write refresh back");

        // R7: switch to synchronous mode, stall active high
        setp(0, 1, 1, 0, 1, 2'b00, 1, 16'h0400); cycle("R7 enter sync mode");

        // R6 R7 R8: standby, initial cycle, following cycle
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 4; j++) begin
                setp(1, 1, 1, 1, 0, 2'b11, 0, 16'h0010); cycle("R2 sync standby");
                setp(0, 0, i[4], i[3], i[2], i[1:0], 0, 16'h0010); cycle("R6 R7 sync initial sweep");
                setp(0, 1, j[1], j[0], 0, i[1:0], 0, 16'h0010); cycle("R8 sync follow sweep");
            end
        end

        // R8: suspend keeps the read burst open
        setp(1, 1, 1, 1, 0, 2'b11, 0, 16'h0010); cycle("R2 standby");
        setp(0, 0, 0, 1, 0, 2'b00, 0, 16'h0010); cycle("R7 initial read");
        setp(0, 1, 1, 1, 0, 2'b00, 0, 16'h0010); cycle("R8 suspend");
        setp(0, 1, 1, 1, 0, 2'b00, 0, 16'h0010); cycle("R8 suspend again");
        setp(0, 1, 0, 1, 0, 2'b01, 0, 16'h0010); cycle("R8 R4 resume upper lane");

        // R6: active-low stall polarity
        setp(1, 1, 1, 1, 0, 2'b11, 0, 16'h0010); cycle("R2 standby");
        setp(0, 0, 1, 0, 1, 2'b00, 1, 16'h0000); cycle("R6 write bus cfg pol low");
        setp(1, 1, 1, 1, 0, 2'b11, 0, 16'h0010); cycle("R2 standby");
        setp(0, 0, 0, 1, 0, 2'b00, 0, 16'h0010); cycle("R6 initial read stall low");
        setp(0, 1, 0, 1, 0, 2'b00, 0, 16'h0010); cycle("R6 continue stall high");
        setp(1, 1, 1, 1, 0, 2'b11, 0, 16'h0010); cycle("R2 standby");
        setp(0, 0, 1, 0, 1, 2'b00, 1, 16'h8400); cycle("R6 R7 back to async");
        setp(1, 1, 1, 1, 0, 2'b11, 0, 16'h0010); cycle("R2 standby");
        setp(0, 1, 0, 1, 0, 2'b00, 0, 16'h0010); cycle("R3 R7 async read after sync");

        // R9 R10: deep power-down
        setp(0, 1, 1, 0, 1, 2'b00, 0, 16'h0000); cycle("R9 arm power-down");
        setp(1, 1, 1, 1, 0, 2'b11, 0, 16'h0000); step();
        chk("R9 entry", {op, dq_oe, arr_rd, arr_wr, stall_oe}, {4'd10, 2'b00, 1'b0, 1'b0, 1'b0});
        for (int k = 0; k < 4; k++) begin
            setp(1, k[0], k[1], k[0], 1, k[1:0], 1, 16'hFFFF); step();
            chk("R9 held and pins ignored", {op, dq_oe, arr_rd, arr_wr, stall_oe, dq_o},
                {4'd10, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0});
        end
        setp(0, 1, 0, 1, 1, 2'b00, 0, 16'h0010); step();
        chk("R10 exit cycle quiet", {op, dq_oe, stall_oe, arr_rd}, {4'd10, 2'b00, 1'b0, 1'b0});
        step();
        chk("R10 refresh restored", {op, dq_o}, {4'd4, 16'h0010});
        setp(0, 1, 0, 1, 1, 2'b00, 1, 16'h0010); step();
        chk("R10 bus cfg restored", {op, dq_o}, {4'd4, 16'h8400});
        setp(1, 1, 1, 1, 0, 2'b11, 0, 16'h0010); step();
        chk("R10 R2 standby not re-entered", {op, stall_oe}, {4'd0, 1'b0});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule